// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block watches one pin of a synchronous GPIO bank and records the precision time at which a chosen edge appears on it. Each record holds the seconds count, the nanoseconds count and a coarse phase code. The phase code takes one of five values, 0 to 4, and stands for an offset in 8 ns steps. Records go into a small bank of sample slots. The first records stay in place until software clears the bank with a single strobe, so later edges never overwrite them.

With rising and falling detection both enabled, the unit splits a pulse into two records: the leading edge goes into slot 0 and the trailing edge into slot 1. Once every slot holds a record, the unit raises a full flag. It then forwards each further qualified edge, tagged by edge type, to the next unit in a chain. A unit placed in chain mode takes its edges from that forwarded pair instead of from its own pin, so a row of units can capture more events from one pin. The default depth is two slots. The `SLOTS` parameter selects a deeper variant, for example eight slots.

Top module: `edge_stamp_unit`

## Requirements
- R1: A qualified edge, seen in the cycle where the selected pin first differs from its value in the previous cycle, stores the `sec_i` and `ns_i` of that same cycle into the next free slot. The record can be read one cycle later.
- R2: A slot that holds a record keeps it, unchanged, until `clr_i`, however many edges arrive after it.
- R3: Slots fill in index order starting at slot 0, so the set of valid slots always forms a contiguous run from slot 0.
- R4: `cfg_i[5]`=1 enables rising-edge capture and `cfg_i[6]`=1 enables falling-edge capture. With both bits set, the first edge of a pulse lands in slot 0 and the opposite edge lands in slot 1.
- R5: `cfg_i[11:8]` selects the watched pin. Edges on every other pin have no effect.
- R6: `clr_i` empties every slot and resets the fill position by the next cycle. An edge that arrives in the same cycle as `clr_i` is not stored.
- R7: The phase code `phase_i` (0..4, meaning 0, 8, 16, 24 or 32 ns) is stored exactly as given, without being added to the time.
- R8: While `en_i`=0, no edge is stored and no edge is forwarded.
- R9: While every slot is valid, `cas_full_o`=1. In the cycle of each further qualified edge, `cas_rise_o` or `cas_fall_o` pulses according to the edge type, and the edge is not stored.
- R10: With `cfg_i[12]`=1 the unit ignores its pin and treats `cas_rise_i` and `cas_fall_i` as its detected edges, still subject to R4 and R8.
- R11: `irq_o` is a level equal to `irq_en_i` AND (any slot valid). It drops when the slots are cleared.
- R12: No edge is detected in the first cycle after reset, so a pin that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | NUM_PINS | Synchronous GPIO bank |
| sec_i | input | 32 | Current seconds count |
| ns_i | input | 30 | Current nanoseconds count |
| phase_i | input | 3 | Sub-sample phase code, 0..4 |
| cfg_i | input | 16 | Configuration word: bit 5 rise, bit 6 fall, bits 11:8 pin, bit 12 chain mode |
| en_i | input | 1 | Capture enable |
| irq_en_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Read-and-clear strobe |
| rd_slot_i | input | IDX_W | Slot to read |
| rd_valid_o | output | 1 | Read slot holds a record |
| rd_sec_o | output | 32 | Read slot seconds |
| rd_ns_o | output | 30 | Read slot nanoseconds |
| rd_phase_o | output | 3 | Read slot phase code |
| irq_o | output | 1 | Interrupt level |
| cas_rise_i | input | 1 | Forwarded rising edge from the previous unit |
| cas_fall_i | input | 1 | Forwarded falling edge from the previous unit |
| cas_full_o | output | 1 | All slots valid |
| cas_rise_o | output | 1 | Forwarded rising edge to the next unit |
| cas_fall_o | output | 1 | Forwarded falling edge to the next unit |

## Verification
A wrong fill pointer or valid vector shows up at the read port one cycle after the edge that exposes it. The record appears in the wrong slot, a valid flag goes missing, or a later edge overwrites an earlier record. `irq_o` and `cas_full_o` show the same fault in that same cycle. A broken edge detector makes the unit store an event with the wrong timestamp, or store nothing at all, in the cycle after the pin change. The forwarding fault can be seen with no delay at all: `cas_rise_o` and `cas_fall_o` are driven combinationally in the cycle of the edge.

// File: rtl/esu_pkg.sv
package esu_pkg;
  localparam int SEC_W       = 32;
  localparam int NS_W        = 30;
  localparam int PH_W        = 3;
  localparam int CFG_W       = 16;
  localparam int CFG_RISE    = 5;
  localparam int CFG_FALL    = 6;
  localparam int CFG_PIN_LSB = 8;
  localparam int CFG_CHAIN   = 12;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
    logic [PH_W-1:0]  ph;
  } stamp_t;
endpackage

// File: rtl/esu_edge_pick.sv
module esu_edge_pick #(
  parameter int NUM_PINS = 16,
  localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] gpio_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                chain_i,
  input  logic                cas_rise_i,
  input  logic                cas_fall_i,
  output logic                rise_o,
  output logic                fall_o
);
  logic [NUM_PINS-1:0] prev_q;
  logic                prime_q;
  logic                cur, old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      prime_q <= 1'b0;
    end else begin
      prev_q  <= gpio_i;
      prime_q <= 1'b1;
    end
  end

  always_comb begin
    cur = 1'b0;
    old = 1'b0;
    if (32'(sel_i) < NUM_PINS) begin
      cur = gpio_i[sel_i];
      old = prev_q[sel_i];
    end
  end

  // first cycle after reset has no valid history
  assign rise_o = chain_i ? cas_rise_i : (prime_q & cur & ~old);
  assign fall_o = chain_i ? cas_fall_i : (prime_q & ~cur & old);
endmodule

// File: rtl/esu_slot_bank.sv
module esu_slot_bank
  import esu_pkg::*;
#(
  parameter int SLOTS  = 2,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  stamp_t           wr_data_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output stamp_t           rd_data_o,
  output logic             rd_valid_o,
  output stamp_t           head_o,
  output logic [SLOTS-1:0] valid_o,
  output logic             full_o
);
  stamp_t           slot_q [SLOTS];
  logic [SLOTS-1:0] valid_q;
  logic [CNT_W-1:0] wp_q;

  assign full_o = &valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 wp_q <= '0;
    else if (clr_i)              wp_q <= '0;
    else if (wr_i && !full_o)    wp_q <= wp_q + 1'b1;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        slot_q[i]  <= '0;
      end else if (clr_i) begin
        valid_q[i] <= 1'b0;
      end else if (wr_i && !full_o && wp_q == CNT_W'(i)) begin
        valid_q[i] <= 1'b1;
        slot_q[i]  <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o  = '0;
    rd_valid_o = 1'b0;
    if (32'(rd_idx_i) < SLOTS) begin
      rd_data_o  = slot_q[rd_idx_i];
      rd_valid_o = valid_q[rd_idx_i];
    end
  end

  assign head_o  = slot_q[0];
  assign valid_o = valid_q;
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import esu_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int SLOTS    = 2,
  localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] gpio_i,
  input  logic [SEC_W-1:0]    sec_i,
  input  logic [NS_W-1:0]     ns_i,
  input  logic [PH_W-1:0]     phase_i,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic                en_i,
  input  logic                irq_en_i,
  input  logic                clr_i,
  input  logic [IDX_W-1:0]    rd_slot_i,
  output logic                rd_valid_o,
  output logic [SEC_W-1:0]    rd_sec_o,
  output logic [NS_W-1:0]     rd_ns_o,
  output logic [PH_W-1:0]     rd_phase_o,
  output logic                irq_o,
  input  logic                cas_rise_i,
  input  logic                cas_fall_i,
  output logic                cas_full_o,
  output logic                cas_rise_o,
  output logic                cas_fall_o
);
  logic             rise_w, fall_w, q_rise, q_fall, wr_w, full_w;
  logic [SLOTS-1:0] valid_w;
  stamp_t           now_w, rd_w, head_w;

  esu_edge_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gpio_i     (gpio_i),
    .sel_i      (cfg_i[CFG_PIN_LSB +: SEL_W]),
    .chain_i    (cfg_i[CFG_CHAIN]),
    .cas_rise_i (cas_rise_i),
    .cas_fall_i (cas_fall_i),
    .rise_o     (rise_w),
    .fall_o     (fall_w)
  );

  assign q_rise = en_i & cfg_i[CFG_RISE] & rise_w;
  assign q_fall = en_i & cfg_i[CFG_FALL] & fall_w;
  assign wr_w   = (q_rise | q_fall) & ~clr_i;
  assign now_w  = '{sec: sec_i, ns: ns_i, ph: phase_i};

  esu_slot_bank #(.SLOTS(SLOTS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_w),
    .wr_data_i  (now_w),
    .clr_i      (clr_i),
    .rd_idx_i   (rd_slot_i),
    .rd_data_o  (rd_w),
    .rd_valid_o (rd_valid_o),
    .head_o     (head_w),
    .valid_o    (valid_w),
    .full_o     (full_w)
  );

  assign rd_sec_o   = rd_w.sec;
  assign rd_ns_o    = rd_w.ns;
  assign rd_phase_o = rd_w.ph;
  assign irq_o      = irq_en_i & (|valid_w);
  assign cas_full_o = full_w;
  // overflow edges go down the chain by type
  assign cas_rise_o = q_rise & full_w;
  assign cas_fall_o = q_fall & full_w;
endmodule

// File: rtl/esu_checker.sv
module esu_checker
  import esu_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             en_i,
  input logic [SLOTS-1:0] valid_i,
  input logic [SEC_W-1:0] head_sec_i,
  input logic [NS_W-1:0]  head_ns_i,
  input logic             cas_rise_i,
  input logic             cas_fall_i
);
  p_keep_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i[0] && !clr_i |=> $stable(head_sec_i) && $stable(head_ns_i));

  p_fill_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(SLOTS'(valid_i + 1'b1)));

  p_clear_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> valid_i == '0);

  p_idle_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> $stable(valid_i));

  p_fwd_not_stored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_rise_i || cas_fall_i) && !clr_i |=> $stable(valid_i));
endmodule

bind edge_stamp_unit esu_checker #(.SLOTS(SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .en_i       (en_i),
  .valid_i    (valid_w),
  .head_sec_i (head_w.sec),
  .head_ns_i  (head_w.ns),
  .cas_rise_i (cas_rise_o),
  .cas_fall_i (cas_fall_o)
);

// File: tb/edge_stamp_unit_tb.sv
`timescale 1ns/100ps
module edge_stamp_unit_tb;
  localparam int NP = 16;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] gpio = '0;
  logic [31:0]   sec = '0;
  logic [29:0]   ns = '0;
  logic [2:0]    phase = '0;
  logic [15:0]   cfg = '0;
  logic          en = 1'b0, irq_en = 1'b0, clr = 1'b0;
  logic          rd_slot = 1'b0;
  logic          cas_ri = 1'b0, cas_fi = 1'b0;
  logic          rd_valid, irq, cas_full, cas_ro, cas_fo;
  logic [31:0]   rd_sec;
  logic [29:0]   rd_ns;
  logic [2:0]    rd_ph;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_sec [NS];
  logic [29:0] m_ns  [NS];
  logic [2:0]  m_ph  [NS];
  int          m_cnt = 0;
  logic [NP-1:0] m_prev = '0;
  bit          m_prime = 0;

  always #2 clk = ~clk;

  edge_stamp_unit #(.NUM_PINS(NP), .SLOTS(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .gpio_i(gpio), .sec_i(sec), .ns_i(ns),
    .phase_i(phase), .cfg_i(cfg), .en_i(en), .irq_en_i(irq_en), .clr_i(clr),
    .rd_slot_i(rd_slot), .rd_valid_o(rd_valid), .rd_sec_o(rd_sec),
    .rd_ns_o(rd_ns), .rd_phase_o(rd_ph), .irq_o(irq),
    .cas_rise_i(cas_ri), .cas_fall_i(cas_fi), .cas_full_o(cas_full),
    .cas_rise_o(cas_ro), .cas_fall_o(cas_fo)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(int pin, bit r, bit f, bit ch);
    logic [15:0] c = '0;
    c[11:8] = 4'(pin);
    c[5] = r; c[6] = f; c[12] = ch;
    return c;
  endfunction

  // one clock: inputs already set at the current negedge
  task automatic tick();
    bit cur, old, r, f, qr, qf, full;
    #0.5;
    cur = gpio[cfg[11:8]];
    old = m_prev[cfg[11:8]];
    r = m_prime & cur & ~old;
    f = m_prime & ~cur & old;
    if (cfg[12]) begin r = cas_ri; f = cas_fi; end
    qr = en & cfg[5] & r;
    qf = en & cfg[6] & f;
    full = (m_cnt == NS);
    check(cas_ro == (qr & full), "R9 cas_rise", longint'(cas_ro), longint'(qr & full));
    check(cas_fo == (qf & full), "R9 cas_fall", longint'(cas_fo), longint'(qf & full));
    @(posedge clk);
    if (clr) m_cnt = 0;
    else if ((qr | qf) && !full) begin
      m_sec[m_cnt] = sec; m_ns[m_cnt] = ns; m_ph[m_cnt] = phase;
      m_cnt++;
    end
    m_prev = gpio;
    m_prime = 1;
    #0.5;
    check(irq == (irq_en && m_cnt > 0), "R11 irq", longint'(irq), longint'(irq_en && m_cnt > 0));
    check(cas_full == (m_cnt == NS), "R9 full", longint'(cas_full), longint'(m_cnt == NS));
    for (int i = 0; i < NS; i++) begin
      rd_slot = 1'(i);
      #0.1;
      check(rd_valid == (i < m_cnt), "R3 valid", longint'(rd_valid), longint'(i < m_cnt));
      if (i < m_cnt) begin
        check(rd_sec == m_sec[i], "R1 sec", longint'(rd_sec), longint'(m_sec[i]));
        check(rd_ns == m_ns[i], "R1 ns", longint'(rd_ns), longint'(m_ns[i]));
        check(rd_ph == m_ph[i], "R7 phase", longint'(rd_ph), longint'(m_ph[i]));
      end
    end
    @(negedge clk);
    clr = 1'b0;
    sec = sec + 1;
    ns = 30'($urandom_range(0, 999_999_999));
    phase = 3'($urandom_range(0, 4));
  endtask

  task automatic count_is(int n, string tag);
    int c = 0;
    for (int i = 0; i < NS; i++) begin
      rd_slot = 1'(i);
      #0.1;
      c += int'(rd_valid);
    end
    check(c == n, tag, c, n);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    tick();
  endtask

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1588));
    // R12: pin high across reset release
    gpio[0] = 1'b1;
    cfg = mk_cfg(0, 1, 0, 0);
    en = 1'b1;
    irq_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #0.5;
    check(rd_valid == 0, "R12 reset valid", longint'(rd_valid), 0);
    check(irq == 0, "R11 reset irq", longint'(irq), 0);
    check(cas_full == 0, "R9 reset full", longint'(cas_full), 0);
    @(negedge clk);
    repeat (3) tick();
    count_is(0, "R12 no edge after reset");

    // R5: other pin ignored
    cfg = mk_cfg(3, 1, 0, 0);
    tick();
    gpio[7] = 1'b1; tick();
    gpio[7] = 1'b0; tick();
    count_is(0, "R5 other pin");
    gpio[3] = 1'b1; phase = 3'd4; tick();
    count_is(1, "R5 selected pin");
    tick();

    // R4 pulse split
    do_clear();
    count_is(0, "R6 clear");
    check(irq == 0, "R11 irq after clear", longint'(irq), 0);
    cfg = mk_cfg(3, 1, 1, 0);
    gpio[3] = 1'b0; tick();
    count_is(1, "R4 first edge");
    gpio[3] = 1'b1; tick();
    count_is(2, "R4 opposite edge");
    // R2/R9 overflow forwarded, slots kept
    gpio[3] = 1'b0; tick();
    gpio[3] = 1'b1; tick();
    count_is(2, "R2 no overwrite");
    check(cas_full == 1, "R9 full flag", longint'(cas_full), 1);

    // R11 mask
    irq_en = 1'b0; tick();
    check(irq == 0, "R11 masked", longint'(irq), 0);
    irq_en = 1'b1;

    // R6 edge in clear cycle dropped
    do_clear();
    cfg = mk_cfg(3, 0, 1, 0);
    gpio[3] = 1'b0; clr = 1'b1; tick();
    count_is(0, "R6 edge with clear");

    // R8 disabled
    en = 1'b0;
    gpio[3] = 1'b1; tick();
    gpio[3] = 1'b0; tick();
    count_is(0, "R8 disabled");
    en = 1'b1;

    // R10 chain input
    cfg = mk_cfg(3, 1, 1, 1);
    gpio[3] = 1'b1; tick();
    gpio[3] = 1'b0; tick();
    count_is(0, "R10 pin ignored in chain mode");
    cas_ri = 1'b1; tick();
    cas_ri = 1'b0; tick();
    count_is(1, "R10 chain rise");
    cas_fi = 1'b1; tick();
    cas_fi = 1'b0; tick();
    count_is(2, "R10 chain fall");
    do_clear();

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int k;
      if ($urandom_range(0, 40) == 0) begin
        k = int'($urandom_range(1, 3));
        cfg = mk_cfg(int'($urandom_range(0, 3)), k[0], k[1], 0);
      end
      for (int p = 0; p < 4; p++)
        if ($urandom_range(0, 5) == 0) gpio[p] = ~gpio[p];
      en = ($urandom_range(0, 9) != 0);
      irq_en = ($urandom_range(0, 7) != 0);
      clr = ($urandom_range(0, 11) == 0);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule